// File: doc/BRIEF.md
# Pipelined Read Output Stage

This block is the output end of a pipelined synchronous SRAM read path. All of its synchronous inputs are sampled on the rising edge of one clock. A read command is formed from two chip enables and a read strobe. The edge that captures the command is the first pipeline stage. During the next cycle the array presents the word, and the following edge loads it into the output register. That edge is the second stage, so the word is shown two edges after its command. Back-to-back reads stream one word per clock after that first latency.

A static mode input sets how the output drivers release after the last word of a burst. In single-cycle deselect mode the drivers let go at the first edge after the final word. In dual-cycle deselect mode the deselect runs one stage deeper, so the drivers stay on for one more full cycle and keep the final word on the bus. The active-low output enable gates the drive request combinationally. A snooze input is sampled each edge. While it is set, new commands are discarded and the drivers are held off. The data already in the output register is kept.

Top module: `rdout_stage`

## Requirements
- R1: While the reset input is low, and right after it is released, dataValid and driveEn are 0.
- R2: A read is captured at edge k when selPos=1, selNeg=0, readStrobe=1 and snooze=0. The word on arrayData between edges k and k+1 then appears on dataOut after edge k+1, with dataValid=1 for that cycle.
- R3: Reads on consecutive edges give one new word per clock, in command order, with dataValid held at 1.
- R4: An edge where selPos=0, selNeg=1 or readStrobe=0 holds no read. Two edges later dataValid is 0 and no new word is loaded.
- R5: With dualDeselect=0 the drive request equals dataValid, so driveEn falls at the first edge after the last word.
- R6: With dualDeselect=1 driveEn stays 1 for one extra cycle after the last word, and dataOut keeps that word during the extra cycle.
- R7: A read captured on the edge right after a non-read edge still shows its word after the usual two edges, in either mode.
- R8: oeN=1 forces driveEn to 0 within the same cycle, with no clock edge needed. Returning oeN to 0 restores the drive request at once.
- R9: snooze=1 at an edge discards the command captured at that edge. It also holds driveEn at 0 from that edge until an edge that samples snooze=0. The contents of the output register are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| selPos | input | 1 | Active-high chip enable |
| selNeg | input | 1 | Active-low chip enable |
| readStrobe | input | 1 | Read request, 1 = read |
| dualDeselect | input | 1 | Static mode: 0 single-cycle, 1 dual-cycle release |
| snooze | input | 1 | Low-power request, sampled each edge |
| oeN | input | 1 | Asynchronous active-low output enable |
| arrayData | input | DATA_W | Word from the array, valid the cycle after the command edge |
| dataOut | output | DATA_W | Registered read word |
| dataValid | output | 1 | dataOut holds the word of a read from two edges earlier |
| driveEn | output | 1 | Enable for the external tri-state data drivers |

## Verification
Two things can happen in the same cycle. The release of the drivers after the last word (single or dual) can coincide with the first cycle of a new read word, and with a change on oeN or snooze. The bench provokes this with read, non-read and read commands placed on consecutive edges in both modes, and with oeN and snooze toggled in the middle of a streaming burst. A behavioural model records at which edges reads and snoozes were taken. From that record it derives the expected driveEn, dataValid and dataOut and compares them with the design every cycle.

// File: rtl/rdout_pkg.sv
package rdout_pkg;
  // Strobes passed from the control pipeline to the data register.
  typedef struct packed {
    logic loadWord;   // a read sits in stage one: capture arrayData at the next edge
    logic wordValid;  // the output register holds a word from a read
    logic tailHold;   // dual release: keep driving for one cycle after the last word
    logic snoozed;    // snooze sampled high at the last edge
  } out_strobes_t;
endpackage

// File: rtl/rdout_ctrl.sv
module rdout_ctrl
  import rdout_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         selPos,
  input  logic         selNeg,
  input  logic         readStrobe,
  input  logic         snooze,
  input  logic         dualDeselect,
  output out_strobes_t strb
);
  logic readCmd;
  logic cmdQ;
  logic wordQ;
  logic tailQ;
  logic snzQ;

  assign readCmd = selPos & ~selNeg & readStrobe & ~snooze;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= 1'b0;
      wordQ <= 1'b0;
      tailQ <= 1'b0;
      snzQ  <= 1'b0;
    end else begin
      snzQ  <= snooze;
      cmdQ  <= readCmd;
      wordQ <= cmdQ;
      tailQ <= wordQ & dualDeselect;
    end
  end

  always_comb begin
    strb.loadWord  = cmdQ;
    strb.wordValid = wordQ;
    strb.tailHold  = tailQ;
    strb.snoozed   = snzQ;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    readCmd |-> ##2 strb.wordValid); // R2

  AST_NONREAD_NO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (!selPos || selNeg || !readStrobe) |-> ##2 !strb.wordValid); // R4

  AST_SNOOZE_DROPS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    snooze |-> ##2 !strb.wordValid); // R9
endmodule

// File: rtl/rdout_dp.sv
module rdout_dp
  import rdout_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              oeN,
  input  out_strobes_t      strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              driveEn
);
  logic [DATA_W-1:0] wordReg;

  always_ff @(posedge clk) begin
    if (!rstN) wordReg <= '0;
    else if (strb.loadWord) wordReg <= arrayData;
  end

  assign dataOut   = wordReg;
  assign dataValid = strb.wordValid;
  assign driveEn   = ~oeN & ~strb.snoozed & (strb.wordValid | strb.tailHold);

  AST_TAIL_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tailHold && !strb.wordValid) |-> $stable(dataOut)); // R6

  AST_DRIVE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> (strb.wordValid || $past(strb.wordValid))); // R5
endmodule

// File: rtl/rdout_stage.sv
module rdout_stage
  import rdout_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selPos,
  input  logic              selNeg,
  input  logic              readStrobe,
  input  logic              dualDeselect,
  input  logic              snooze,
  input  logic              oeN,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              driveEn
);
  out_strobes_t strb;

  rdout_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .selPos(selPos), .selNeg(selNeg),
    .readStrobe(readStrobe), .snooze(snooze), .dualDeselect(dualDeselect),
    .strb(strb)
  );

  rdout_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .arrayData(arrayData), .oeN(oeN), .strb(strb),
    .dataOut(dataOut), .dataValid(dataValid), .driveEn(driveEn)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!dataValid && !driveEn)); // R1
endmodule

// File: tb/rdout_stage_tb_top.sv
`timescale 1ns/1ps
module rdout_stage_tb_top;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selPos = 1'b0, selNeg = 1'b1, readStrobe = 1'b0;
  logic dualDeselect = 1'b0, snooze = 1'b0, oeN = 1'b0;
  logic [DW-1:0] arrayData = '0;
  logic [DW-1:0] dataOut;
  logic dataValid, driveEn;

  int checks = 0;
  int bad = 0;
  int edgeCnt = 0;
  bit running = 1'b0;
  string curReq = "R1";
  bit readAt[int];
  bit snzAt[int];

  always #5 clk = ~clk;

  rdout_stage #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .selPos(selPos), .selNeg(selNeg),
    .readStrobe(readStrobe), .dualDeselect(dualDeselect), .snooze(snooze),
    .oeN(oeN), .arrayData(arrayData), .dataOut(dataOut),
    .dataValid(dataValid), .driveEn(driveEn)
  );

  function automatic logic [DW-1:0] pattern(int e);
    return 32'h5A00_0000 ^ (e * 32'h0001_0203) ^ 32'h0000_00C3;
  endfunction

  function automatic bit rdAt(int e);
    return readAt.exists(e) ? readAt[e] : 1'b0;
  endfunction

  function automatic bit szAt(int e);
    return snzAt.exists(e) ? snzAt[e] : 1'b0;
  endfunction

  // Record which edges took a read or a snooze.
  always @(posedge clk) begin
    if (rstN) begin
      edgeCnt = edgeCnt + 1;
      readAt[edgeCnt] = selPos && !selNeg && readStrobe && !snooze;
      snzAt[edgeCnt]  = snooze;
    end
  end

  // Array model: the word for a read at edge e is presented until edge e+1.
  always @(negedge clk) arrayData <= pattern(edgeCnt);

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", curReq, what, act, exp);
    end
  endtask

  // Reference comparison every cycle, away from the edge.
  always @(negedge clk) begin
    #2;
    if (running && rstN) begin
      automatic bit expValid = rdAt(edgeCnt - 1);
      automatic bit expTail  = dualDeselect && rdAt(edgeCnt - 2);
      automatic bit expDrive = !oeN && !szAt(edgeCnt) && (expValid || expTail);
      automatic int lastRd = -1;
      for (int e = edgeCnt - 1; e >= 1; e--) begin
        if (rdAt(e)) begin lastRd = e; break; end
      end
      check("dataValid", {31'b0, dataValid}, {31'b0, expValid});
      check("driveEn", {31'b0, driveEn}, {31'b0, expDrive});
      if (lastRd > 0 && (expValid || expTail))
        check("dataOut", dataOut, pattern(lastRd));
    end
  end

  task automatic step(bit p, bit n, bit r, bit z);
    @(negedge clk);
    selPos = p; selNeg = n; readStrobe = r; snooze = z;
  endtask

  task automatic rd();   step(1, 0, 1, 0); endtask
  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(0, 1, 0, 0);
  endtask

  task automatic doReset(bit dual);
    running = 1'b0;
    @(negedge clk);
    rstN = 1'b0; selPos = 0; selNeg = 1; readStrobe = 0; snooze = 0; oeN = 0;
    dualDeselect = dual;
    repeat (3) @(negedge clk);
    #1;
    curReq = "R1";
    check("dataValid in reset", {31'b0, dataValid}, 32'd0); // R1
    check("driveEn in reset", {31'b0, driveEn}, 32'd0);     // R1
    readAt.delete(); snzAt.delete(); edgeCnt = 0;
    rstN = 1'b1;
    running = 1'b1;
  endtask

  task automatic scenarios();
    curReq = "R2"; rd(); idle(3);
    curReq = "R3"; repeat (4) rd(); idle(3);
    curReq = "R4";
    step(1, 1, 1, 0); step(0, 0, 1, 0); step(1, 0, 0, 0); idle(3);
    curReq = "R7"; rd(); idle(1); rd(); rd(); idle(1); rd(); idle(3);
    curReq = "R8";
    repeat (2) rd();
    step(1, 0, 1, 0); #4 oeN = 1'b1; #2;
    check("driveEn mid-cycle with oeN high", {31'b0, driveEn}, 32'd0); // R8
    rd(); oeN = 1'b1; rd(); oeN = 1'b0; #4;
    check("driveEn restored with oeN low", {31'b0, driveEn}, 32'd1); // R8
    rd(); idle(3);
    curReq = "R9";
    rd(); rd(); step(1, 0, 1, 1); step(1, 0, 1, 1); rd(); rd(); step(0, 1, 0, 1); idle(4);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL %s watchdog expired act=running exp=finished", curReq);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    doReset(1'b0);
    @(negedge clk); #3;
    curReq = "R1";
    check("dataValid after release", {31'b0, dataValid}, 32'd0); // R1
    curReq = "R5";
    scenarios();                     // single-cycle release, R5 in every cycle
    doReset(1'b1);
    curReq = "R6"; rd(); idle(4); repeat (3) rd(); idle(4);
    scenarios();                     // dual-cycle release, R6 tail in every cycle
    running = 1'b0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule